// File: doc/BRIEF.md
# Byte-Lane Tag Store with Compare

This block is a synchronous tag store. Each entry is an 18-bit word, and the store can hold a small number of entries. The word is split into two 9-bit lanes that can be written separately. A single global-write strobe overrides the lane controls and writes the whole word.

Incoming data does not go straight into the array. It first lands in a gated data-input register. Every write copies that register's contents into the selected lanes. The same register is compared, without a clock, against the word stored at the presented address, which gives a hit flag for tag lookups.

A sequencer drives the address and a cycle-type bit (write or read). On read cycles the stored word also comes out on a registered read port, one clock after the address is presented.

Top module: `bytelane_tag_mem`

## Requirements
- R1: The word splits into two lanes. Bits 8:0 form the low lane and are controlled by `lane_lo_n`. Bits 17:9 form the high lane and are controlled by `lane_hi_n`.
- R2: On a clock edge where `wr_cycle` is 1, a lane is written from the data-input register only when both `bw_gate_n` and that lane's enable are 0. When `bw_gate_n` is 1, the lane enables have no effect.
- R3: With `wr_cycle` at 1 and `glob_wr_n` at 0, both lanes are written. This holds whatever the values of `bw_gate_n`, `lane_lo_n` and `lane_hi_n`.
- R4: The data-input register loads `din` on a rising edge when `din_en_n` is 0, and holds its value otherwise. Reset clears it to zero. A write on the same edge uses the value the register held before that edge.
- R5: While `cmp_oe_n` is 0, `hit` is 1 exactly when the data-input register equals the word stored at the current `addr`. This is combinational, so it follows a change of `addr` within the same cycle.
- R6: While `cmp_oe_n` is 1, `hit` is 0.
- R7: On an edge where `wr_cycle` is 0, `rd_data` takes the word stored at `addr`. On write edges `rd_data` holds its value. Reset clears `rd_data` to zero.
- R8: On edges where no write condition holds, no lane of any entry changes.
- R9: After a write of both lanes that leaves the data-input register unchanged, a compare at that address with `cmp_oe_n` at 0 reports `hit` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Entry address |
| wr_cycle | input | 1 | 1 = write cycle, 0 = read cycle |
| glob_wr_n | input | 1 | Full-word write override, active low |
| bw_gate_n | input | 1 | Gate for the lane enables, active low |
| lane_lo_n | input | 1 | Low-lane write enable, active low |
| lane_hi_n | input | 1 | High-lane write enable, active low |
| din_en_n | input | 1 | Data-input register load enable, active low |
| din | input | 18 | Data into the input register |
| cmp_oe_n | input | 1 | Compare output enable, active low |
| rd_data | output | 18 | Registered read word |
| hit | output | 1 | Compare result |

## Verification
The bench builds the block with AW = 4, which gives 16 entries. It first fills every entry, so that every later compare and read has a known reference word.

With a depth this small, random addresses land on the same entries again and again. As a result, partial lane writes, gated-off writes and reads come back to entries whose history the bench model knows. The same-edge interplay between a write and a new load of the input register is also reached often.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;
  localparam int WORD_W = 18;
  localparam int LANES  = 2;
  localparam int LANE_W = WORD_W / LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_mask_t;
endpackage

// File: rtl/tm_write_ctl.sv
module tm_write_ctl
  import tagmem_pkg::*;
(
  input  logic       wr_cycle,
  input  logic       glob_wr_n,
  input  logic       bw_gate_n,
  input  lane_mask_t lane_en_n,
  output lane_mask_t lane_we
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      lane_we[g] = wr_cycle & (~glob_wr_n | (~bw_gate_n & ~lane_en_n[g]));
    end
  end
endmodule

// File: rtl/tm_din_reg.sv
module tm_din_reg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (!load_n) q <= d;
  end
endmodule

// File: rtl/tm_lane_bank.sv
module tm_lane_bank #(
  parameter int AW = 4,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  input  logic          rd_en,
  output logic [W-1:0]  rd_q,
  output logic [W-1:0]  peek
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[addr];
  end

  assign peek = mem[addr];
endmodule

// File: rtl/tm_match.sv
module tm_match #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         oe_n,
  output logic         hit
);
  always_comb hit = ~oe_n & (a == b);
endmodule

// File: rtl/bytelane_tag_mem.sv
module bytelane_tag_mem
  import tagmem_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_cycle,
  input  logic          glob_wr_n,
  input  logic          bw_gate_n,
  input  logic          lane_lo_n,
  input  logic          lane_hi_n,
  input  logic          din_en_n,
  input  logic [17:0]   din,
  input  logic          cmp_oe_n,
  output logic [17:0]   rd_data,
  output logic          hit
);
  word_t      din_q;
  word_t      stored;
  lane_mask_t lane_we;
  lane_mask_t lane_en_n;

  assign lane_en_n = {lane_hi_n, lane_lo_n};

  tm_write_ctl u_wctl (
    .wr_cycle (wr_cycle),
    .glob_wr_n(glob_wr_n),
    .bw_gate_n(bw_gate_n),
    .lane_en_n(lane_en_n),
    .lane_we  (lane_we)
  );

  tm_din_reg #(.W(WORD_W)) u_din (
    .clk   (clk),
    .rst   (rst),
    .load_n(din_en_n),
    .d     (din),
    .q     (din_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    tm_lane_bank #(.AW(AW), .W(LANE_W)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .addr (addr),
      .we   (lane_we[g]),
      .wdata(din_q[g*LANE_W +: LANE_W]),
      .rd_en(~wr_cycle),
      .rd_q (rd_data[g*LANE_W +: LANE_W]),
      .peek (stored[g*LANE_W +: LANE_W])
    );
  end

  tm_match #(.W(WORD_W)) u_cmp (
    .a   (din_q),
    .b   (stored),
    .oe_n(cmp_oe_n),
    .hit (hit)
  );
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          wr_cycle,
  input logic          glob_wr_n,
  input logic          bw_gate_n,
  input logic          din_en_n,
  input logic          cmp_oe_n,
  input logic [17:0]   rd_data,
  input logic          hit,
  input logic [17:0]   din_q,
  input logic [1:0]    lane_we
);
  AST_HIT_OFF: assert property (@(posedge clk) disable iff (rst) cmp_oe_n |-> !hit); // R6
  AST_DIN_HOLD: assert property (@(posedge clk) disable iff (rst) din_en_n |=> $stable(din_q)); // R4
  AST_GLOBAL_FULL: assert property (@(posedge clk) disable iff (rst) (wr_cycle && !glob_wr_n) |-> (lane_we == 2'b11)); // R3
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst) (glob_wr_n && bw_gate_n) |-> (lane_we == 2'b00)); // R2
  AST_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !wr_cycle |-> (lane_we == 2'b00)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) wr_cycle |=> $stable(rd_data)); // R7
  AST_HIT_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_cycle && !glob_wr_n && din_en_n) |=> ((addr == $past(addr) && !cmp_oe_n) -> hit)); // R9
endmodule

bind bytelane_tag_mem tm_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_cycle (wr_cycle),
  .glob_wr_n(glob_wr_n),
  .bw_gate_n(bw_gate_n),
  .din_en_n (din_en_n),
  .cmp_oe_n (cmp_oe_n),
  .rd_data  (rd_data),
  .hit      (hit),
  .din_q    (din_q),
  .lane_we  (lane_we)
);

// File: tb/sim_bytelane_tag_mem.sv
`timescale 1ns/1ps
module sim_bytelane_tag_mem;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          wr_cycle, glob_wr_n, bw_gate_n, lane_lo_n, lane_hi_n, din_en_n, cmp_oe_n;
  logic [17:0]   din;
  logic [17:0]   rd_data;
  logic          hit;

  int n_checks = 0;
  int n_fail   = 0;

  logic [17:0] m_mem [DEPTH];
  logic [17:0] m_din;
  logic [17:0] m_rd;

  always #2.5 clk = ~clk;

  bytelane_tag_mem #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_cycle(wr_cycle), .glob_wr_n(glob_wr_n),
    .bw_gate_n(bw_gate_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .din_en_n(din_en_n), .din(din), .cmp_oe_n(cmp_oe_n), .rd_data(rd_data), .hit(hit)
  );

  function automatic logic [17:0] next_word(input logic [17:0] old, input logic [17:0] src,
                                            input logic wr, input logic gw, input logic bw,
                                            input logic lo, input logic hi);
    logic [17:0] r;
    r = old;
    if (wr && (!gw || (!bw && !lo))) r[8:0]  = src[8:0];
    if (wr && (!gw || (!bw && !hi))) r[17:9] = src[17:9];
    return r;
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [AW-1:0] a, input logic wr, input logic gw,
                     input logic bw, input logic lo, input logic hi, input logic den,
                     input logic [17:0] d, input logic oe);
    logic [17:0] old_din;
    logic        exp_hit;
    @(negedge clk);
    addr = a; wr_cycle = wr; glob_wr_n = gw; bw_gate_n = bw; lane_lo_n = lo; lane_hi_n = hi;
    din_en_n = den; din = d; cmp_oe_n = oe;
    @(posedge clk);
    #1;
    old_din = m_din;
    if (!wr) m_rd = m_mem[a];
    m_mem[a] = next_word(m_mem[a], old_din, wr, gw, bw, lo, hi);
    if (!den) m_din = d;
    exp_hit = !oe && (m_din == m_mem[a]);
    check({tag, " R7 rd_data"}, rd_data, m_rd);
    check({tag, oe ? " R6 hit" : " R5 hit"}, {17'd0, hit}, {17'd0, exp_hit});
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [17:0] w;
    void'($urandom(32'd1234));
    rst = 1'b1; addr = '0; wr_cycle = 0; glob_wr_n = 1; bw_gate_n = 1; lane_lo_n = 1;
    lane_hi_n = 1; din_en_n = 1; din = '0; cmp_oe_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset rd_data", rd_data, 18'd0);
    check("R6 reset hit", {17'd0, hit}, 18'd0);
    @(negedge clk); rst = 1'b0;
    m_din = '0; m_rd = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 18'h0;

    // Fill every entry with global writes (R3); each uses the previous load.
    for (int i = 0; i < DEPTH; i++)
      cyc("fill R3", AW'(i), 1, 0, 1, 1, 1, 0, 18'($urandom), 0);
    cyc("fill R3", AW'(0), 1, 0, 1, 1, 1, 1, 18'd0, 0);

    // R1 / R2: low-lane-only write, then read back.
    cyc("R4 load", 4'd3, 0, 1, 1, 1, 1, 0, 18'h2AB5C, 0);
    cyc("R1 low lane", 4'd3, 1, 1, 0, 0, 1, 1, 18'd0, 0);
    cyc("R1 readback", 4'd3, 0, 1, 1, 1, 1, 1, 18'd0, 0);
    w = m_mem[3];
    check("R1 low lane bits", {9'd0, rd_data[8:0]}, {9'd0, 9'h15C});
    // High lane only.
    cyc("R1 high lane", 4'd5, 1, 1, 0, 1, 0, 1, 18'd0, 0);
    cyc("R1 readback hi", 4'd5, 0, 1, 1, 1, 1, 1, 18'd0, 0);
    check("R1 high lane bits", {9'd0, rd_data[17:9]}, {9'd0, 9'h155});
    // R2: gate high blocks lane enables.
    cyc("R4 load2", 4'd7, 0, 1, 1, 1, 1, 0, 18'h3FFFF, 0);
    w = m_mem[7];
    cyc("R2 gate off", 4'd7, 1, 1, 1, 0, 0, 1, 18'd0, 0);
    cyc("R2 readback", 4'd7, 0, 1, 1, 1, 1, 1, 18'd0, 0);
    check("R2 unchanged", rd_data, w);
    // R8: read cycle with all strobes low writes nothing.
    w = m_mem[9];
    cyc("R8 read strobes", 4'd9, 0, 0, 0, 0, 0, 1, 18'd0, 0);
    cyc("R8 readback", 4'd9, 0, 1, 1, 1, 1, 1, 18'd0, 0);
    check("R8 unchanged", rd_data, w);
    // R3 + R9: global write with lanes off, then compare hits.
    cyc("R3 global", 4'd11, 1, 0, 1, 1, 1, 1, 18'd0, 0);
    check("R9 hit after write", {17'd0, hit}, 18'd1);
    // R5: change address same cycle -> combinational compare.
    cyc("R5 other addr", 4'd12, 0, 1, 1, 1, 1, 1, 18'd0, 0);
    // R4: hold without enable.
    cyc("R4 hold", 4'd11, 0, 1, 1, 1, 1, 1, 18'h00001, 0);
    check("R4 hold hit", {17'd0, hit}, 18'd1);
    // R6: oe high masks a true match.
    cyc("R6 oe high", 4'd11, 0, 1, 1, 1, 1, 1, 18'd0, 1);
    check("R6 masked", {17'd0, hit}, 18'd0);

    // Random mix.
    for (int k = 0; k < 3000; k++) begin
      cyc("rand", AW'($urandom), 1'($urandom), 1'(($urandom % 4) != 0), 1'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), 18'($urandom), 1'(($urandom % 5) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule